// File: doc/BRIEF.md
# Interrupt-Level Banked Register File

This block holds the working registers of a small processor that runs at one of four interrupt levels. Every level owns a private bank of sixteen 16-bit registers. Register 0 of each bank is that level's instruction pointer, and registers 1 to 15 are general purpose. An arbiter tracks the current level. It moves to a higher requested level, or drops back when the running handler releases its level. Level changes happen only when the sequencer signals an instruction boundary, so an instruction never starts in one bank and finishes in another.

Software reaches the same storage in two ways. The sequencer uses a word-wide register port, addressed by level and register index. The byte-wide storage port covers the lowest 128 bytes of read/write storage. There, byte address = level×32 + register×2 + byte select, and byte select 0 addresses the high byte.

The register port is never back-pressured. The storage window is a valid/ready port. A window transfer completes on a clock edge where `win_valid` and `win_ready` are both high. `win_ready` drops only in a cycle where the register port writes. The window master must then hold its request until the next cycle. Read data on both ports is combinational from the addressed location.

Top module: `irqbank_top`

## Requirements
- R1: After reset, the current level is 0, every register in every bank reads 0, and `win_ready` is high.
- R2: A register-port write (`reg_valid` and `reg_we` high at a clock edge) stores `reg_wdata` into bank `reg_level`, register `reg_idx`. `reg_rdata` always shows the value at the location that `reg_level`/`reg_idx` address.
- R3: `win_rdata` shows the byte at window address `win_addr`. Bits [6:5] select the level, bits [4:1] select the register, and bit 0 selects the byte: 0 is bits [15:8] and 1 is bits [7:0].
- R4: An accepted window write (`win_valid`, `win_ready` and `win_we` high at an edge) replaces only the addressed byte. The other byte of that register is unchanged.
- R5: `win_ready` is low exactly in cycles where `reg_valid` and `reg_we` are both high. A window write offered in such a cycle changes nothing, and the register write takes place.
- R6: `cur_ip` always equals register 0 of the bank of the current level.
- R7: `cur_level` changes only at a clock edge where `insn_boundary` is high. Requests and release pulses alone do not move it.
- R8: At a boundary with no release outstanding, the level becomes the larger of the current level and the highest-numbered request bit set. Request bit 0 has no effect, and lower-numbered requests never preempt a higher current level.
- R9: A `release_in` pulse stays remembered until the next boundary, or takes effect at once if it coincides with one. At that boundary the level becomes the highest-numbered request set, or 0 if none is set, and the remembered release is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 4 | Interrupt request per level, bit n for level n |
| insn_boundary | input | 1 | Sequencer strobe: the current instruction is complete |
| release_in | input | 1 | Running handler gives up its level |
| cur_level | output | 2 | Current interrupt level |
| cur_ip | output | 16 | Instruction pointer (register 0) of the current level |
| reg_valid | input | 1 | Register-port request |
| reg_we | input | 1 | Register-port write enable |
| reg_level | input | 2 | Register-port bank select |
| reg_idx | input | 4 | Register-port register index |
| reg_wdata | input | 16 | Register-port write data |
| reg_rdata | output | 16 | Register-port read data |
| win_valid | input | 1 | Window request valid |
| win_ready | output | 1 | Window request accepted this cycle |
| win_we | input | 1 | Window write enable |
| win_addr | input | 7 | Window byte address |
| win_wdata | input | 8 | Window write byte |
| win_rdata | output | 8 | Window read byte |

## Verification
The assertions check these properties on every cycle:
- The level holds between boundaries.
- A level-3 request always wins at a boundary.
- `win_ready` falls during register writes.
- An accepted window byte reads back.
- The two access paths agree whenever they address the same register.
- `cur_ip` matches register 0 of the current bank.

Only the bench's scenarios can show the following:
- The full priority table from every starting level, with and without release.
- The remembered release across idle cycles.
- That a stalled window write really leaves storage untouched.

These come from sweeps over all 64 registers, all 128 window bytes and every request pattern.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int DEF_LEVELS = 4;
  localparam int DEF_REGS   = 16;
  localparam int DEF_WIDTH  = 16;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_REG  = 2'd1,
    WR_WIN  = 2'd2
  } wr_src_e;
endpackage

// File: rtl/irqbank_arbiter.sv
module irqbank_arbiter #(
  parameter int NUM_LEVELS = irqbank_pkg::DEF_LEVELS,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irq_req,
  input  logic                  insn_boundary,
  input  logic                  release_in,
  output logic [LVL_W-1:0]      cur_level
);
  logic [LVL_W-1:0] top_req;
  logic [LVL_W-1:0] next_level;
  logic             rel_pend_q;
  logic             rel_eff;

  // highest-numbered request wins; bit 0 maps to level 0, same as none
  always_comb begin
    top_req = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (irq_req[i]) top_req = LVL_W'(i);
    end
  end

  assign rel_eff = rel_pend_q | release_in;

  always_comb begin
    next_level = cur_level;
    if (insn_boundary) begin
      if (rel_eff)                   next_level = top_req;
      else if (top_req > cur_level)  next_level = top_req;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_level  <= '0;
      rel_pend_q <= 1'b0;
    end else begin
      cur_level <= next_level;
      if (insn_boundary)   rel_pend_q <= 1'b0;
      else if (release_in) rel_pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irqbank_window.sv
module irqbank_window #(
  parameter int NUM_LEVELS = irqbank_pkg::DEF_LEVELS,
  parameter int NUM_REGS   = irqbank_pkg::DEF_REGS,
  parameter int DATA_W     = irqbank_pkg::DEF_WIDTH,
  localparam int BYTES  = DATA_W / 8,
  localparam int BSEL_W = $clog2(BYTES),
  localparam int SEL_W  = $clog2(NUM_LEVELS * NUM_REGS),
  localparam int AW     = SEL_W + BSEL_W
) (
  input  logic [AW-1:0]     win_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] word_in,
  output logic [SEL_W-1:0]  win_sel,
  output logic [BSEL_W-1:0] win_lane,
  output logic              win_ready,
  output logic [7:0]        win_rdata
);
  logic [BSEL_W-1:0] bsel;

  assign win_sel  = win_addr[AW-1:BSEL_W];
  assign bsel     = win_addr[BSEL_W-1:0];
  // byte select 0 names the most significant byte
  assign win_lane = BSEL_W'(BYTES - 1) - bsel;

  // register port owns the storage write path during its write cycles
  assign win_ready = ~reg_wr;

  assign win_rdata = word_in[win_lane*8 +: 8];
endmodule

// File: rtl/irqbank_store.sv
module irqbank_store #(
  parameter int NUM_LEVELS = irqbank_pkg::DEF_LEVELS,
  parameter int NUM_REGS   = irqbank_pkg::DEF_REGS,
  parameter int DATA_W     = irqbank_pkg::DEF_WIDTH,
  localparam int ENTRIES = NUM_LEVELS * NUM_REGS,
  localparam int SEL_W   = $clog2(ENTRIES),
  localparam int BSEL_W  = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_wsel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              win_wr,
  input  logic [SEL_W-1:0]  win_wsel,
  input  logic [BSEL_W-1:0] win_lane,
  input  logic [7:0]        win_wdata,
  input  logic [SEL_W-1:0]  rsel_a,
  input  logic [SEL_W-1:0]  rsel_b,
  input  logic [SEL_W-1:0]  rsel_ip,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  output logic [DATA_W-1:0] rdata_ip
);
  import irqbank_pkg::*;

  logic [DATA_W-1:0] words [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [DATA_W-1:0] q;
    wr_src_e           src;

    always_comb begin
      if (reg_wr && reg_wsel == SEL_W'(e))      src = WR_REG;
      else if (win_wr && win_wsel == SEL_W'(e)) src = WR_WIN;
      else                                      src = WR_NONE;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        case (src)
          WR_REG:  q <= reg_wdata;
          WR_WIN:  q[win_lane*8 +: 8] <= win_wdata;
          default: q <= q;
        endcase
      end
    end

    assign words[e] = q;
  end

  assign rdata_a  = words[rsel_a];
  assign rdata_b  = words[rsel_b];
  assign rdata_ip = words[rsel_ip];
endmodule

// File: rtl/irqbank_top.sv
module irqbank_top #(
  parameter int NUM_LEVELS = irqbank_pkg::DEF_LEVELS,
  parameter int NUM_REGS   = irqbank_pkg::DEF_REGS,
  parameter int DATA_W     = irqbank_pkg::DEF_WIDTH,
  localparam int LVL_W  = $clog2(NUM_LEVELS),
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int BSEL_W = $clog2(DATA_W / 8),
  localparam int SEL_W  = LVL_W + IDX_W,
  localparam int AW     = SEL_W + BSEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irq_req,
  input  logic                  insn_boundary,
  input  logic                  release_in,
  output logic [LVL_W-1:0]      cur_level,
  output logic [DATA_W-1:0]     cur_ip,
  input  logic                  reg_valid,
  input  logic                  reg_we,
  input  logic [LVL_W-1:0]      reg_level,
  input  logic [IDX_W-1:0]      reg_idx,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  win_valid,
  output logic                  win_ready,
  input  logic                  win_we,
  input  logic [AW-1:0]         win_addr,
  input  logic [7:0]            win_wdata,
  output logic [7:0]            win_rdata
);
  logic              reg_wr;
  logic              win_wr;
  logic [SEL_W-1:0]  reg_sel;
  logic [SEL_W-1:0]  win_sel;
  logic [SEL_W-1:0]  ip_sel;
  logic [BSEL_W-1:0] win_lane;
  logic [DATA_W-1:0] win_word;

  assign reg_wr  = reg_valid & reg_we;
  assign win_wr  = win_valid & win_we & win_ready;
  assign reg_sel = {reg_level, reg_idx};
  assign ip_sel  = {cur_level, IDX_W'(0)};

  irqbank_arbiter #(.NUM_LEVELS(NUM_LEVELS)) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req       (irq_req),
    .insn_boundary (insn_boundary),
    .release_in    (release_in),
    .cur_level     (cur_level)
  );

  irqbank_window #(
    .NUM_LEVELS (NUM_LEVELS),
    .NUM_REGS   (NUM_REGS),
    .DATA_W     (DATA_W)
  ) u_win (
    .win_addr  (win_addr),
    .reg_wr    (reg_wr),
    .word_in   (win_word),
    .win_sel   (win_sel),
    .win_lane  (win_lane),
    .win_ready (win_ready),
    .win_rdata (win_rdata)
  );

  irqbank_store #(
    .NUM_LEVELS (NUM_LEVELS),
    .NUM_REGS   (NUM_REGS),
    .DATA_W     (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wsel  (reg_sel),
    .reg_wdata (reg_wdata),
    .win_wr    (win_wr),
    .win_wsel  (win_sel),
    .win_lane  (win_lane),
    .win_wdata (win_wdata),
    .rsel_a    (reg_sel),
    .rsel_b    (win_sel),
    .rsel_ip   (ip_sel),
    .rdata_a   (reg_rdata),
    .rdata_b   (win_word),
    .rdata_ip  (cur_ip)
  );
endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk #(
  parameter int NUM_LEVELS = irqbank_pkg::DEF_LEVELS,
  parameter int NUM_REGS   = irqbank_pkg::DEF_REGS,
  parameter int DATA_W     = irqbank_pkg::DEF_WIDTH,
  localparam int LVL_W  = $clog2(NUM_LEVELS),
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int BSEL_W = $clog2(DATA_W / 8),
  localparam int AW     = LVL_W + IDX_W + BSEL_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LEVELS-1:0] irq_req,
  input logic                  insn_boundary,
  input logic [LVL_W-1:0]      cur_level,
  input logic [DATA_W-1:0]     cur_ip,
  input logic                  reg_valid,
  input logic                  reg_we,
  input logic [LVL_W-1:0]      reg_level,
  input logic [IDX_W-1:0]      reg_idx,
  input logic [DATA_W-1:0]     reg_rdata,
  input logic                  win_valid,
  input logic                  win_ready,
  input logic                  win_we,
  input logic [AW-1:0]         win_addr,
  input logic [7:0]            win_wdata,
  input logic [7:0]            win_rdata
);
  logic same_reg;
  logic [7:0] alias_byte;

  assign same_reg = (reg_level == win_addr[AW-1 -: LVL_W]) &&
                    (reg_idx == win_addr[BSEL_W +: IDX_W]);
  assign alias_byte = reg_rdata[(DATA_W/8 - 1 - int'(win_addr[BSEL_W-1:0]))*8 +: 8];

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_boundary |=> $stable(cur_level));

  // R8
  top_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_boundary && irq_req[NUM_LEVELS-1]) |=> (cur_level == LVL_W'(NUM_LEVELS-1)));

  // R5
  win_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_we) |-> !win_ready);

  // R4
  win_write_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready && win_we) |=> ($stable(win_addr) |-> (win_rdata == $past(win_wdata))));

  // R3
  path_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    same_reg |-> (win_rdata == alias_byte));

  // R6
  ip_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_level == cur_level && reg_idx == '0) |-> (reg_rdata == cur_ip));
endmodule

bind irqbank_top irqbank_chk #(
  .NUM_LEVELS (NUM_LEVELS),
  .NUM_REGS   (NUM_REGS),
  .DATA_W     (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_req       (irq_req),
  .insn_boundary (insn_boundary),
  .cur_level     (cur_level),
  .cur_ip        (cur_ip),
  .reg_valid     (reg_valid),
  .reg_we        (reg_we),
  .reg_level     (reg_level),
  .reg_idx       (reg_idx),
  .reg_rdata     (reg_rdata),
  .win_valid     (win_valid),
  .win_ready     (win_ready),
  .win_we        (win_we),
  .win_addr      (win_addr),
  .win_wdata     (win_wdata),
  .win_rdata     (win_rdata)
);

// File: tb/sim_irqbank_top.sv
module sim_irqbank_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  irq_req;
  logic        insn_boundary;
  logic        release_in;
  logic [1:0]  cur_level;
  logic [15:0] cur_ip;
  logic        reg_valid;
  logic        reg_we;
  logic [1:0]  reg_level;
  logic [3:0]  reg_idx;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        win_valid;
  logic        win_ready;
  logic        win_we;
  logic [6:0]  win_addr;
  logic [7:0]  win_wdata;
  logic [7:0]  win_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [15:0] mdl [4][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqbank_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_boundary(insn_boundary),
    .release_in(release_in), .cur_level(cur_level), .cur_ip(cur_ip),
    .reg_valid(reg_valid), .reg_we(reg_we), .reg_level(reg_level), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_valid(win_valid),
    .win_ready(win_ready), .win_we(win_we), .win_addr(win_addr),
    .win_wdata(win_wdata), .win_rdata(win_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive and sample a quarter period after the rising edge
  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  function automatic logic [1:0] top_of(input logic [3:0] p);
    logic [1:0] t = 2'd0;
    for (int i = 1; i < 4; i++) if (p[i]) t = 2'(i);
    return t;
  endfunction

  task automatic set_level(input int s);
    irq_req = (s == 0) ? 4'b0000 : 4'(1 << s);
    release_in = 1'b1;
    insn_boundary = 1'b1;
    tick();
    irq_req = '0; release_in = 1'b0; insn_boundary = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; insn_boundary = 1'b0; release_in = 1'b0;
    reg_valid = 1'b0; reg_we = 1'b0; reg_level = '0; reg_idx = '0; reg_wdata = '0;
    win_valid = 1'b0; win_we = 1'b0; win_addr = '0; win_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 level", 32'(cur_level), 32'd0);
    check("R1 ready", 32'(win_ready), 32'd1);
    for (int l = 0; l < 4; l++)
      for (int i = 0; i < 16; i++) begin
        reg_level = 2'(l); reg_idx = 4'(i); #1;
        check("R1 reg zero", 32'(reg_rdata), 32'd0);
        mdl[l][i] = '0;
      end

    // R2 write every register through the register port
    reg_valid = 1'b1; reg_we = 1'b1;
    for (int l = 0; l < 4; l++)
      for (int i = 0; i < 16; i++) begin
        reg_level = 2'(l); reg_idx = 4'(i);
        reg_wdata = 16'((l << 12) | (i << 8) | (((l * 16 + i) ^ 8'hA5) & 8'hFF));
        mdl[l][i] = reg_wdata;
        tick();
      end
    reg_valid = 1'b0; reg_we = 1'b0;
    for (int l = 0; l < 4; l++)
      for (int i = 0; i < 16; i++) begin
        reg_level = 2'(l); reg_idx = 4'(i); #1;
        check("R2 readback", 32'(reg_rdata), 32'(mdl[l][i]));
      end

    // R3 every window byte: addr = level*32 + reg*2 + b, b=0 high byte
    for (int a = 0; a < 128; a++) begin
      win_addr = 7'(a); #1;
      check("R3 window byte", 32'(win_rdata),
            32'((a % 2 == 0) ? mdl[a/32][(a%32)/2][15:8] : mdl[a/32][(a%32)/2][7:0]));
    end

    // R4 write the high byte of every register through the window
    win_valid = 1'b1; win_we = 1'b1;
    for (int a = 0; a < 128; a += 2) begin
      win_addr = 7'(a); win_wdata = 8'((a * 3 + 7) & 8'hFF);
      mdl[a/32][(a%32)/2][15:8] = win_wdata;
      tick();
    end
    win_valid = 1'b0; win_we = 1'b0;
    for (int l = 0; l < 4; l++)
      for (int i = 0; i < 16; i++) begin
        reg_level = 2'(l); reg_idx = 4'(i); #1;
        check("R4 byte merge", 32'(reg_rdata), 32'(mdl[l][i]));
      end

    // R5 collision on the same register: register write wins
    reg_valid = 1'b1; reg_we = 1'b1; reg_level = 2'd1; reg_idx = 4'd5; reg_wdata = 16'hBEEF;
    win_valid = 1'b1; win_we = 1'b1; win_addr = 7'(1*32 + 5*2 + 1); win_wdata = 8'h33;
    #1; check("R5 ready low", 32'(win_ready), 32'd0);
    tick(); mdl[1][5] = 16'hBEEF;
    reg_valid = 1'b0; reg_we = 1'b0; win_valid = 1'b0; win_we = 1'b0; #1;
    check("R5 reg wins", 32'(reg_rdata), 32'hBEEF);
    check("R5 ready back", 32'(win_ready), 32'd1);
    // R5 stalled window write to another register has no effect
    reg_valid = 1'b1; reg_we = 1'b1; reg_level = 2'd3; reg_idx = 4'd3; reg_wdata = 16'h1234;
    win_valid = 1'b1; win_we = 1'b1; win_addr = 7'h40; win_wdata = 8'h5A;
    tick(); mdl[3][3] = 16'h1234;
    reg_valid = 1'b0; reg_we = 1'b0; win_valid = 1'b0; win_we = 1'b0; #1;
    check("R5 stalled write dropped", 32'(win_rdata), 32'(mdl[2][0][15:8]));
    // R5 a read offered with no register write is accepted
    reg_valid = 1'b1; reg_we = 1'b0; win_valid = 1'b1; #1;
    check("R5 read ready", 32'(win_ready), 32'd1);
    reg_valid = 1'b0; win_valid = 1'b0;

    // R7 requests without a boundary do not move the level
    irq_req = 4'hF; tick(); tick();
    check("R7 no boundary", 32'(cur_level), 32'd0);
    irq_req = '0;

    // R8 / R9 / R6 sweep over start level, request pattern and release
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 16; p++)
        for (int r = 0; r < 2; r++) begin
          logic [1:0] exp;
          set_level(s);
          check("R9 set level", 32'(cur_level), 32'(s));
          irq_req = 4'(p); release_in = 1'(r); insn_boundary = 1'b1;
          tick();
          irq_req = '0; release_in = 1'b0; insn_boundary = 1'b0;
          if (r == 1) exp = top_of(4'(p));
          else exp = (top_of(4'(p)) > 2'(s)) ? top_of(4'(p)) : 2'(s);
          check(r ? "R9 release select" : "R8 priority", 32'(cur_level), 32'(exp));
          check("R6 ip", 32'(cur_ip), 32'(mdl[exp][0]));
        end

    // R9 release remembered across idle cycles
    set_level(3);
    release_in = 1'b1; tick(); release_in = 1'b0;
    tick();
    check("R7 release alone", 32'(cur_level), 32'd3);
    irq_req = 4'b0010; insn_boundary = 1'b1; tick(); insn_boundary = 1'b0;
    check("R9 delayed release", 32'(cur_level), 32'd1);
    irq_req = 4'b0000; insn_boundary = 1'b1; tick(); insn_boundary = 1'b0;
    check("R9 release cleared", 32'(cur_level), 32'd1);

    // R6 instruction pointer follows a register-port update
    reg_valid = 1'b1; reg_we = 1'b1; reg_level = 2'd1; reg_idx = 4'd0; reg_wdata = 16'h0F0E;
    tick(); reg_valid = 1'b0; reg_we = 1'b0; #1;
    check("R6 ip update", 32'(cur_ip), 32'h0F0E);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule